// File: doc/BRIEF.md
# Display Controller Control, Status and Interrupt Core

This block is the control and status heart of a display controller. It sits next to a frame fetch engine and a timing generator, and it turns their event strobes into sticky status bits and a single interrupt line. A control word holds the run enable, the panel type, the load mode, a set of interrupt enables and the line-status clearing select. A status word records frame starts, frame ends after a shutdown, FIFO underflow, loss of sync, line matches, AC-bias count events and palette-load completion.

Turning the controller off is not immediate. When software clears the enable bit, the core keeps the controller running until the timing logic reports the end of the current frame. Only then does it drop busy and raise the done status. Each status bit has its own clearing rule: some clear on a write of one, some on disable, one on re-enable, and the palette bit changes its rule with the load mode.

Top module: `lcdc_core`

## Requirements
- R1: After reset, or at any reset while running, the control word, status word, busy and irq are all zero.
- R2: A control write keeps bit 0 (enable), bits 6..2 (interrupt enables: bit 2 vsync, bit 3 done, bit 4 palette, bit 5 line-no-interrupt, bit 6 line), bit 7 (panel type, 1 = active matrix), bit 10 (line clear select) and bits 21..20 (load mode: 0 palette and frame, 1 palette only, 2 frame only); all other bits read back as zero.
- R3: Writing enable = 1 while the controller is idle raises busy from the next cycle on.
- R4: After enable is written to 0, busy stays high until a frame-end strobe is seen; on that edge busy falls and status bit 0 (done) is set. Writing enable = 1 again before the frame end cancels the shutdown, and a later frame end then does nothing.
- R5: Events are recorded only while busy: frame start sets bit 1, sync lost bit 2, AC-bias count bit 3, line match bit 4, FIFO underflow bit 5, palette loaded bit 6; all are sticky.
- R6: A status write clears bits 1, 3 and 4 wherever a one is written; ones written to bits 0, 2 and 5 have no effect.
- R7: Status bit 6 clears by a status write of one only in load mode 1; in the other modes it ignores writes and clears when enable is written from 1 to 0, a disable that leaves it set in mode 1.
- R8: Writing enable from 1 to 0 clears status bits 2 and 5.
- R9: Done stays set until enable is written from 0 to 1; that write clears it.
- R10: With control bit 10 set, a frame start while busy also clears status bit 4.
- R11: irq is high when done and its enable (bit 3), vsync and bit 2, palette and bit 4, or line and bit 6 are both set, or whenever status bit 2 or 5 is set; bit 3 of status never raises irq.
- R12: When an event and a clear for the same status bit fall in the same cycle, the event wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_wr | input | 1 | Write strobe for the control word |
| stat_wr | input | 1 | Write strobe for the status word (write-one-to-clear bits) |
| wr_data | input | DATA_W | Write data shared by both strobes |
| ev_frame_start | input | 1 | Frame start strobe from timing logic |
| ev_frame_end | input | 1 | End of frame strobe from timing logic |
| ev_sync_lost | input | 1 | Sync lost strobe |
| ev_acb | input | 1 | AC-bias count strobe |
| ev_line | input | 1 | Line match strobe |
| ev_underflow | input | 1 | FIFO underflow strobe from the fetch engine |
| ev_pal_loaded | input | 1 | Palette load complete strobe |
| ctrl_word | output | DATA_W | Current control word |
| stat_word | output | 7 | Current status word |
| irq | output | 1 | Combined interrupt line |
| busy | output | 1 | High from enable until the shutdown finishes |

## Verification
The hardest case to reach is the shutdown window: the controller has been disabled but is still draining, and in that window software may re-enable it, or a frame end may arrive. The stimulus table first runs the controller and disables it with done enabled, then delivers a frame start and a frame end to watch done arrive. It later disables in palette-only mode, re-enables before any frame end and sends a frame end, which must leave busy high and done clear. Same-cycle collisions of an event with a write clear and with the automatic line clear are placed as explicit rows.

// File: rtl/lcdc_pkg.sv
package lcdc_pkg;

    localparam int CTRL_W = 22;
    localparam int STAT_W = 7;

    // control bit positions
    localparam int C_EN      = 0;
    localparam int C_IE_VS   = 2;
    localparam int C_IE_DONE = 3;
    localparam int C_IE_PAL  = 4;
    localparam int C_IE_LNN  = 5;
    localparam int C_IE_LINE = 6;
    localparam int C_PANEL   = 7;
    localparam int C_LCLR    = 10;
    localparam int C_MODE    = 20;

    typedef enum logic [1:0] {
        LM_BOTH     = 2'd0,
        LM_PAL_ONLY = 2'd1,
        LM_FRAME    = 2'd2,
        LM_RSVD     = 2'd3
    } load_mode_e;

    typedef enum logic [1:0] {
        RUN_IDLE   = 2'd0,
        RUN_ACTIVE = 2'd1,
        RUN_DRAIN  = 2'd2
    } run_e;

    // status layout, MSB first so that bit indices match the status word
    typedef struct packed {
        logic pal;
        logic fuf;
        logic line;
        logic acb;
        logic sync;
        logic vsync;
        logic done;
    } stat_t;

    typedef struct packed {
        logic pal_loaded;
        logic underflow;
        logic line_hit;
        logic ac_bias;
        logic sync_lost;
        logic frame_end;
        logic frame_start;
    } evt_t;

    function automatic logic [CTRL_W-1:0] ctrl_keep_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        m[C_EN] = 1'b1;
        for (int i = C_IE_VS; i <= C_PANEL; i++) m[i] = 1'b1;
        m[C_LCLR] = 1'b1;
        m[C_MODE] = 1'b1;
        m[C_MODE+1] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/lcdc_ctrl_reg.sv
module lcdc_ctrl_reg
    import lcdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              en_rise,
    output logic              en_fall
);
    localparam logic [CTRL_W-1:0] KEEP = ctrl_keep_mask();

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else if (wr) ctrl_q <= wdata & KEEP;
    end

    assign en_rise = wr &  wdata[C_EN] & ~ctrl_q[C_EN];
    assign en_fall = wr & ~wdata[C_EN] &  ctrl_q[C_EN];
endmodule

// File: rtl/lcdc_run_seq.sv
module lcdc_run_seq
    import lcdc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_rise,
    input  logic en_fall,
    input  logic frame_end,
    output logic busy,
    output logic done_set
);
    run_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RUN_IDLE:   if (en_rise) st_d = RUN_ACTIVE;
            RUN_ACTIVE: if (en_fall) st_d = RUN_DRAIN;
            RUN_DRAIN: begin
                if (en_rise)        st_d = RUN_ACTIVE;
                else if (frame_end) st_d = RUN_IDLE;
            end
            default:    st_d = RUN_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= RUN_IDLE;
        else     st_q <= st_d;
    end

    assign busy     = (st_q != RUN_IDLE);
    assign done_set = (st_q == RUN_DRAIN) & frame_end & ~en_rise;
endmodule

// File: rtl/lcdc_stat_reg.sv
module lcdc_stat_reg
    import lcdc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  evt_t              ev,
    input  logic              busy,
    input  logic              done_set,
    input  logic              en_rise,
    input  logic              en_fall,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic              pal_only,
    input  logic              line_auto,
    output stat_t             stat_q
);
    stat_t set_v, clr_v;
    logic  [STAT_W-1:0] q_bits;
    logic  unused_wbits;

    assign unused_wbits = wdata[0] ^ wdata[2] ^ wdata[5];

    always_comb begin
        set_v.done  = done_set;
        set_v.vsync = busy & ev.frame_start;
        set_v.sync  = busy & ev.sync_lost;
        set_v.acb   = busy & ev.ac_bias;
        set_v.line  = busy & ev.line_hit;
        set_v.fuf   = busy & ev.underflow;
        set_v.pal   = busy & ev.pal_loaded;

        clr_v.done  = en_rise;
        clr_v.vsync = wr & wdata[1];
        clr_v.sync  = en_fall;
        clr_v.acb   = wr & wdata[3];
        clr_v.line  = (wr & wdata[4]) | (line_auto & busy & ev.frame_start);
        clr_v.fuf   = en_fall;
        clr_v.pal   = pal_only ? (wr & wdata[6]) : en_fall;
    end

    // one sticky flop per bit: a set beats a clear
    for (genvar b = 0; b < STAT_W; b++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q_bits[b] <= 1'b0;
            else     q_bits[b] <= set_v[b] | (q_bits[b] & ~clr_v[b]);
        end
    end

    assign stat_q = stat_t'(q_bits);
endmodule

// File: rtl/lcdc_core.sv
module lcdc_core
    import lcdc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_wr,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ev_frame_start,
    input  logic              ev_frame_end,
    input  logic              ev_sync_lost,
    input  logic              ev_acb,
    input  logic              ev_line,
    input  logic              ev_underflow,
    input  logic              ev_pal_loaded,
    output logic [DATA_W-1:0] ctrl_word,
    output logic [STAT_W-1:0] stat_word,
    output logic              irq,
    output logic              busy
);
    logic [CTRL_W-1:0] ctrl_q;
    logic              en_rise, en_fall, done_set;
    stat_t             st;
    evt_t              ev;
    load_mode_e        mode;
    logic              unused_hi;

    assign unused_hi = ^wr_data[DATA_W-1:CTRL_W];

    assign ev = '{pal_loaded: ev_pal_loaded, underflow: ev_underflow,
                  line_hit: ev_line, ac_bias: ev_acb, sync_lost: ev_sync_lost,
                  frame_end: ev_frame_end, frame_start: ev_frame_start};

    lcdc_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr      (ctrl_wr),
        .wdata   (wr_data[CTRL_W-1:0]),
        .ctrl_q  (ctrl_q),
        .en_rise (en_rise),
        .en_fall (en_fall)
    );

    lcdc_run_seq u_run (
        .clk       (clk),
        .rst       (rst),
        .en_rise   (en_rise),
        .en_fall   (en_fall),
        .frame_end (ev_frame_end),
        .busy      (busy),
        .done_set  (done_set)
    );

    assign mode = load_mode_e'(ctrl_q[C_MODE+1:C_MODE]);

    lcdc_stat_reg u_stat (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .busy      (busy),
        .done_set  (done_set),
        .en_rise   (en_rise),
        .en_fall   (en_fall),
        .wr        (stat_wr),
        .wdata     (wr_data[STAT_W-1:0]),
        .pal_only  (mode == LM_PAL_ONLY),
        .line_auto (ctrl_q[C_LCLR]),
        .stat_q    (st)
    );

    assign irq = (st.done  & ctrl_q[C_IE_DONE])
               | (st.vsync & ctrl_q[C_IE_VS])
               | (st.pal   & ctrl_q[C_IE_PAL])
               | (st.line  & ctrl_q[C_IE_LINE])
               | st.sync | st.fuf;

    assign ctrl_word = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
    assign stat_word = st;
endmodule

// File: rtl/lcdc_core_chk.sv
module lcdc_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       ctrl_wr,
    input logic       wr_d0,
    input logic       en,
    input logic       ev_frame_end,
    input logic       ev_underflow,
    input logic       ev_sync_lost,
    input logic [6:0] stat_word,
    input logic       irq,
    input logic       busy
);
    assert_start_R3: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && wr_d0 && !en && !busy) |=> busy);

    assert_drain_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !en && !ev_frame_end) |=> busy);

    assert_drain_done_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && !en && ev_frame_end && !(ctrl_wr && wr_d0)) |=> (!busy && stat_word[0]));

    assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (stat_word[0] && !(ctrl_wr && wr_d0)) |=> stat_word[0]);

    assert_err_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_wr && !wr_d0 && en && !ev_underflow && !ev_sync_lost)
        |=> (!stat_word[2] && !stat_word[5]));

    assert_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (stat_word == 7'd0) |-> !irq);

    assert_err_irq_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && (ev_underflow || ev_sync_lost)) |=> irq);
endmodule

bind lcdc_core lcdc_core_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .ctrl_wr      (ctrl_wr),
    .wr_d0        (wr_data[0]),
    .en           (ctrl_word[0]),
    .ev_frame_end (ev_frame_end),
    .ev_underflow (ev_underflow),
    .ev_sync_lost (ev_sync_lost),
    .stat_word    (stat_word),
    .irq          (irq),
    .busy         (busy)
);

// File: tb/tb_lcdc_core.sv
module tb_lcdc_core;
    localparam int DATA_W = 32;
    localparam int NV     = 27;

    typedef struct packed {
        logic        cw;
        logic        sw;
        logic [31:0] d;
        logic [6:0]  ev;   // [0]fstart [1]fend [2]sync [3]acb [4]line [5]underflow [6]pal
        logic [6:0]  st;
        logic        bz;
        logic        iq;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 32'h0000_0001, 7'h00, 7'h00, 1'b1, 1'b0}, // 0  R3 start
        '{1'b0, 1'b0, 32'h0,         7'h01, 7'h02, 1'b1, 1'b0}, // 1  R5 vsync
        '{1'b1, 1'b0, 32'h0000_0005, 7'h00, 7'h02, 1'b1, 1'b1}, // 2  R11 vsync enable
        '{1'b0, 1'b1, 32'h0000_0002, 7'h00, 7'h00, 1'b1, 1'b0}, // 3  R6 w1c
        '{1'b0, 1'b0, 32'h0,         7'h18, 7'h18, 1'b1, 1'b0}, // 4  R5 acb+line
        '{1'b1, 1'b0, 32'h0000_0045, 7'h00, 7'h18, 1'b1, 1'b1}, // 5  R11 line enable
        '{1'b0, 1'b1, 32'h0000_007F, 7'h00, 7'h00, 1'b1, 1'b0}, // 6  R6 clear all
        '{1'b0, 1'b0, 32'h0,         7'h20, 7'h20, 1'b1, 1'b1}, // 7  R11 underflow
        '{1'b0, 1'b1, 32'h0000_0020, 7'h00, 7'h20, 1'b1, 1'b1}, // 8  R6 ignored
        '{1'b0, 1'b0, 32'h0,         7'h40, 7'h60, 1'b1, 1'b1}, // 9  R5 pal
        '{1'b1, 1'b0, 32'h0000_0008, 7'h00, 7'h00, 1'b1, 1'b0}, // 10 R8 disable
        '{1'b0, 1'b0, 32'h0,         7'h01, 7'h02, 1'b1, 1'b0}, // 11 R4 draining
        '{1'b0, 1'b0, 32'h0,         7'h02, 7'h03, 1'b0, 1'b1}, // 12 R4 done
        '{1'b0, 1'b0, 32'h0,         7'h04, 7'h03, 1'b0, 1'b1}, // 13 R5 idle ignore
        '{1'b0, 1'b1, 32'h0000_0001, 7'h00, 7'h03, 1'b0, 1'b1}, // 14 R9 no w1c
        '{1'b1, 1'b0, 32'h0010_0001, 7'h00, 7'h02, 1'b1, 1'b0}, // 15 R9 re-enable
        '{1'b0, 1'b0, 32'h0,         7'h40, 7'h42, 1'b1, 1'b0}, // 16 R5 pal
        '{1'b0, 1'b1, 32'h0000_0040, 7'h00, 7'h02, 1'b1, 1'b0}, // 17 R7 w1c mode1
        '{1'b0, 1'b0, 32'h0,         7'h40, 7'h42, 1'b1, 1'b0}, // 18 R5 pal
        '{1'b1, 1'b0, 32'h0010_0000, 7'h00, 7'h42, 1'b1, 1'b0}, // 19 R7 disable keeps
        '{1'b1, 1'b0, 32'h0010_0001, 7'h00, 7'h42, 1'b1, 1'b0}, // 20 R4 cancel
        '{1'b0, 1'b0, 32'h0,         7'h02, 7'h42, 1'b1, 1'b0}, // 21 R4 no done
        '{1'b1, 1'b0, 32'h0000_0401, 7'h00, 7'h42, 1'b1, 1'b0}, // 22 R2 mode change
        '{1'b0, 1'b0, 32'h0,         7'h10, 7'h52, 1'b1, 1'b0}, // 23 R5 line
        '{1'b0, 1'b0, 32'h0,         7'h01, 7'h42, 1'b1, 1'b0}, // 24 R10 auto clear
        '{1'b0, 1'b0, 32'h0,         7'h11, 7'h52, 1'b1, 1'b0}, // 25 R12 set wins
        '{1'b0, 1'b1, 32'h0000_0012, 7'h01, 7'h42, 1'b1, 1'b0}  // 26 R12 set wins
    };

    function automatic string vtag(int i);
        case (i)
            0: return "R3";
            2, 5, 7: return "R11";
            3, 6, 8: return "R6";
            10: return "R8";
            11, 12, 20, 21: return "R4";
            14, 15: return "R9";
            17, 19: return "R7";
            22: return "R2";
            24: return "R10";
            25, 26: return "R12";
            default: return "R5";
        endcase
    endfunction

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ctrl_wr = 1'b0, stat_wr = 1'b0;
    logic [DATA_W-1:0] wr_data = '0;
    logic              ev_frame_start = 1'b0, ev_frame_end = 1'b0, ev_sync_lost = 1'b0;
    logic              ev_acb = 1'b0, ev_line = 1'b0, ev_underflow = 1'b0, ev_pal_loaded = 1'b0;
    logic [DATA_W-1:0] ctrl_word;
    logic [6:0]        stat_word;
    logic              irq, busy;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    lcdc_core #(.DATA_W(DATA_W)) dut (
        .clk(clk), .rst(rst), .ctrl_wr(ctrl_wr), .stat_wr(stat_wr), .wr_data(wr_data),
        .ev_frame_start(ev_frame_start), .ev_frame_end(ev_frame_end),
        .ev_sync_lost(ev_sync_lost), .ev_acb(ev_acb), .ev_line(ev_line),
        .ev_underflow(ev_underflow), .ev_pal_loaded(ev_pal_loaded),
        .ctrl_word(ctrl_word), .stat_word(stat_word), .irq(irq), .busy(busy)
    );

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        ctrl_wr = 1'b0; stat_wr = 1'b0; wr_data = '0;
        {ev_pal_loaded, ev_underflow, ev_line, ev_acb, ev_sync_lost, ev_frame_end, ev_frame_start} = '0;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected below 5000", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: state after reset
        check("R1", {ctrl_word, 25'd0, stat_word, busy, irq}, 64'd0);

        for (int i = 0; i < NV; i++) begin
            ctrl_wr = VEC[i].cw;
            stat_wr = VEC[i].sw;
            wr_data = VEC[i].d;
            {ev_pal_loaded, ev_underflow, ev_line, ev_acb, ev_sync_lost,
             ev_frame_end, ev_frame_start} = VEC[i].ev;
            @(negedge clk);
            check(vtag(i), {55'd0, stat_word, busy, irq},
                  {55'd0, VEC[i].st, VEC[i].bz, VEC[i].iq});
        end
        idle_inputs();

        // R2: only defined control bits are kept
        ctrl_wr = 1'b1; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        idle_inputs();
        check("R2", {32'd0, ctrl_word}, {32'd0, 32'h0030_04FD});
        // R11: all enables set, done clear, pal and vsync set -> irq
        @(negedge clk);
        check("R11", {62'd0, busy, irq}, {62'd0, 1'b1, 1'b1});

        // R1: reset in the middle of a run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        check("R1", {ctrl_word, 25'd0, stat_word, busy, irq}, 64'd0);

        finish_run();
    end
endmodule